// File: doc/BRIEF.md
# Periodic Wake Timer

This block produces a periodic interrupt from a slow timer clock. The period is set by a 12-bit compare value and an enable bit, both written from a faster bus clock. A write is taken into a shadow register on the bus side. It then crosses into the timer domain through a toggle handshake and restarts the count there. The timer fires a one-cycle pulse every compare value + 1 timer cycles. A compare value of zero, or a cleared enable, parks the timer. Every pulse also sets a sticky flag in the bus domain, and a one-cycle clear strobe on the bus side clears it.

The bus side runs a two-state handshake machine. In BUS_IDLE, a write launches a transfer and moves to BUS_WAIT. In BUS_WAIT, an acknowledge goes back to BUS_IDLE, or launches the pending value and stays in BUS_WAIT if another write arrived during the transfer. The timer side has three states. TMR_IDLE does not count. TMR_WARM is entered on every load of an active value and lasts two cycles. TMR_RUN counts and pulses, and moves on when TMR_WARM ends. A load of an inactive value returns the timer to TMR_IDLE from any state. A load of an active value re-enters TMR_WARM from any state. Because of TMR_WARM, the first pulse after a load comes two cycles later than a normal period.

Top module: `periodic_wake_timer`

## Requirements
- R1: After reset, tick_irq and flag are 0, and no pulse appears until a configuration is written.
- R2: A written compare value of 0, or a write with cfg_en = 0, stops the timer: no tick_irq pulse follows once the value has reached the timer domain.
- R3: Each write is carried across with a toggle handshake. The transferred value stays stable until it is acknowledged. A write made during a transfer is delivered after it, so the last written value takes effect.
- R4: While running, tick_irq is a single-cycle pulse, and consecutive pulses are exactly compare value + 1 timer cycles apart.
- R5: A nonzero compare value of 1, 2 or 3 behaves as 4, which gives a period of 5 timer cycles. The value 4 also gives 5, and 5 gives 6.
- R6: The timer domain takes in a written value on the third timer edge after the bus edge that samples cfg_we. The first pulse follows N + 3 timer edges later, where N is the clamped value, so it lands N + 6 timer edges after the write (within one edge for clock phase).
- R7: Writing a new active value while running restarts the count, and the first pulse then follows R6 timing from the new write.
- R8: Every pulse sets flag within six bus cycles. flag then stays 1 without further pulses until it is cleared.
- R9: flag_clr = 1 for one bus cycle clears flag on the next bus edge unless a pulse arrives in that same cycle, in which case the set wins. flag_clr = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bus clock |
| bus_rst | input | 1 | Synchronous reset, bus domain, active high |
| cfg_we | input | 1 | One-cycle write strobe for cfg_en and cfg_val |
| cfg_en | input | 1 | Enable bit written with the compare value |
| cfg_val | input | 12 | Compare value |
| flag_clr | input | 1 | Write-1 clear strobe for flag |
| flag | output | 1 | Sticky interrupt flag, bus domain |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst | input | 1 | Synchronous reset, timer domain, active high |
| tick_irq | output | 1 | One-cycle periodic interrupt pulse, timer domain |

## Verification
A wrong warm-up length or a wrong counter limit moves the first pulse away from N + 6 edges after a write. It also changes the spacing of the following pulses, so the error is visible at tick_irq within one period. A lost or stale handshake leaves the timer on the old period, or on the value before the last of two close writes; this shows within one or two periods after the write. A broken flag path shows within a few bus cycles of a pulse or a clear strobe.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    // Bus-side handshake machine
    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_WAIT = 1'b1
    } bus_st_e;

    // Timer-side counting machine
    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_WARM = 2'd1,
        TMR_RUN  = 2'd2
    } tmr_st_e;

    // Flops in each synchronizer chain
    localparam int unsigned PWT_SYNC_STAGES = 2;

endpackage

// File: rtl/pwt_sync.sv
module pwt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pwt_bus_ctrl.sv
module pwt_bus_ctrl
    import pwt_pkg::*;
#(
    parameter int unsigned CW = 12
) (
    input  logic          bus_clk,
    input  logic          bus_rst,
    input  logic          cfg_we,
    input  logic          cfg_en,
    input  logic [CW-1:0] cfg_val,
    input  logic          ack_tgl,
    output logic          req_tgl,
    output logic          xfer_en,
    output logic [CW-1:0] xfer_val,
    output logic          busy,
    output logic          ack_match
);
    bus_st_e       state_q, state_d;
    logic          ack_s;
    logic          launch;
    logic          pend_q;
    logic          shadow_en_q;
    logic [CW-1:0] shadow_val_q;

    pwt_sync #(.STAGES(PWT_SYNC_STAGES)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_tgl),
        .q   (ack_s)
    );

    assign ack_match = (ack_s == req_tgl);
    assign busy      = (state_q == BUS_WAIT);

    // Next state and launch decision
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (cfg_we) begin
                    launch  = 1'b1;
                    state_d = BUS_WAIT;
                end
            end
            BUS_WAIT: begin
                if (ack_match) begin
                    if (pend_q || cfg_we) begin
                        launch = 1'b1;
                    end else begin
                        state_d = BUS_IDLE;
                    end
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shadow, pending and transfer registers
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            shadow_en_q  <= 1'b0;
            shadow_val_q <= '0;
            pend_q       <= 1'b0;
            req_tgl      <= 1'b0;
            xfer_en      <= 1'b0;
            xfer_val     <= '0;
        end else begin
            if (cfg_we) begin
                shadow_en_q  <= cfg_en;
                shadow_val_q <= cfg_val;
            end
            if (launch) begin
                req_tgl  <= ~req_tgl;
                pend_q   <= 1'b0;
                xfer_en  <= cfg_we ? cfg_en  : shadow_en_q;
                xfer_val <= cfg_we ? cfg_val : shadow_val_q;
            end else if (cfg_we) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwt_flag.sv
module pwt_flag
    import pwt_pkg::*;
(
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic evt_tgl,
    input  logic flag_clr,
    output logic flag,
    output logic evt_seen
);
    logic evt_s;
    logic evt_prev_q;

    pwt_sync #(.STAGES(PWT_SYNC_STAGES)) u_evt_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (evt_tgl),
        .q   (evt_s)
    );

    assign evt_seen = evt_s ^ evt_prev_q;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            evt_prev_q <= 1'b0;
            flag       <= 1'b0;
        end else begin
            evt_prev_q <= evt_s;
            if (evt_seen) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwt_rx.sv
module pwt_rx
    import pwt_pkg::*;
(
    input  logic tmr_clk,
    input  logic tmr_rst,
    input  logic req_tgl,
    output logic ack_tgl,
    output logic load_p
);
    logic req_s;
    logic req_prev_q;

    pwt_sync #(.STAGES(PWT_SYNC_STAGES)) u_req_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (req_tgl),
        .q   (req_s)
    );

    assign load_p = req_s ^ req_prev_q;

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            req_prev_q <= 1'b0;
            ack_tgl    <= 1'b0;
        end else begin
            req_prev_q <= req_s;
            if (load_p) begin
                ack_tgl <= req_s;
            end
        end
    end
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter
    import pwt_pkg::*;
#(
    parameter int unsigned CW      = 12,
    parameter int unsigned MIN_CMP = 4
) (
    input  logic          tmr_clk,
    input  logic          tmr_rst,
    input  logic          load_p,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_val,
    output logic          tick_irq,
    output logic          evt_tgl,
    output tmr_st_e       state_q,
    output logic [CW-1:0] run_lim
);
    localparam logic [CW-1:0] FLOOR = CW'(MIN_CMP);

    tmr_st_e       state_d;
    logic          ld_active;
    logic [CW-1:0] ld_lim;
    logic          warm_q;
    logic [CW-1:0] cnt_q;

    assign ld_active = ld_en && (ld_val != '0);
    assign ld_lim    = (ld_val < FLOOR) ? FLOOR : ld_val;

    // Next state
    always_comb begin
        state_d = state_q;
        if (load_p) begin
            state_d = ld_active ? TMR_WARM : TMR_IDLE;
        end else begin
            unique case (state_q)
                TMR_IDLE: state_d = TMR_IDLE;
                TMR_WARM: state_d = warm_q ? TMR_RUN : TMR_WARM;
                TMR_RUN:  state_d = TMR_RUN;
                default:  state_d = TMR_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            state_q <= TMR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and outputs
    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            run_lim  <= FLOOR;
            cnt_q    <= '0;
            warm_q   <= 1'b0;
            tick_irq <= 1'b0;
            evt_tgl  <= 1'b0;
        end else if (load_p) begin
            run_lim  <= ld_lim;
            cnt_q    <= '0;
            warm_q   <= 1'b0;
            tick_irq <= 1'b0;
        end else begin
            unique case (state_q)
                TMR_IDLE: begin
                    tick_irq <= 1'b0;
                end
                TMR_WARM: begin
                    warm_q   <= 1'b1;
                    cnt_q    <= '0;
                    tick_irq <= 1'b0;
                end
                TMR_RUN: begin
                    if (cnt_q == run_lim) begin
                        cnt_q    <= '0;
                        tick_irq <= 1'b1;
                        evt_tgl  <= ~evt_tgl;
                    end else begin
                        cnt_q    <= cnt_q + 1'b1;
                        tick_irq <= 1'b0;
                    end
                end
                default: begin
                    tick_irq <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/periodic_wake_timer.sv
module periodic_wake_timer
    import pwt_pkg::*;
#(
    parameter int unsigned CW      = 12,
    parameter int unsigned MIN_CMP = 4
) (
    input  logic          bus_clk,
    input  logic          bus_rst,
    input  logic          cfg_we,
    input  logic          cfg_en,
    input  logic [CW-1:0] cfg_val,
    input  logic          flag_clr,
    output logic          flag,
    input  logic          tmr_clk,
    input  logic          tmr_rst,
    output logic          tick_irq
);
    logic          req_tgl;
    logic          ack_tgl;
    logic          xfer_en;
    logic [CW-1:0] xfer_val;
    logic          busy;
    logic          ack_match;
    logic          load_p;
    logic          evt_tgl;
    logic          evt_seen;
    tmr_st_e       tmr_state;
    logic [CW-1:0] run_lim;

    pwt_bus_ctrl #(.CW(CW)) u_bus (
        .bus_clk   (bus_clk),
        .bus_rst   (bus_rst),
        .cfg_we    (cfg_we),
        .cfg_en    (cfg_en),
        .cfg_val   (cfg_val),
        .ack_tgl   (ack_tgl),
        .req_tgl   (req_tgl),
        .xfer_en   (xfer_en),
        .xfer_val  (xfer_val),
        .busy      (busy),
        .ack_match (ack_match)
    );

    pwt_rx u_rx (
        .tmr_clk (tmr_clk),
        .tmr_rst (tmr_rst),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl),
        .load_p  (load_p)
    );

    pwt_counter #(.CW(CW), .MIN_CMP(MIN_CMP)) u_cnt (
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .load_p   (load_p),
        .ld_en    (xfer_en),
        .ld_val   (xfer_val),
        .tick_irq (tick_irq),
        .evt_tgl  (evt_tgl),
        .state_q  (tmr_state),
        .run_lim  (run_lim)
    );

    pwt_flag u_flag (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .evt_tgl  (evt_tgl),
        .flag_clr (flag_clr),
        .flag     (flag),
        .evt_seen (evt_seen)
    );
endmodule

// File: rtl/pwt_checks.sv
module pwt_checks
    import pwt_pkg::*;
#(
    parameter int unsigned CW      = 12,
    parameter int unsigned MIN_CMP = 4
) (
    input logic          bus_clk,
    input logic          bus_rst,
    input logic          tmr_clk,
    input logic          tmr_rst,
    input logic          tick_irq,
    input logic          flag,
    input logic          flag_clr,
    input logic          evt_seen,
    input logic          busy,
    input logic          ack_match,
    input logic          xfer_en,
    input logic [CW-1:0] xfer_val,
    input tmr_st_e       tmr_state,
    input logic [CW-1:0] run_lim
);
    // R4: the interrupt is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        tick_irq |=> !tick_irq);

    // R2: a parked timer raises no pulse
    a_r2_idle_quiet: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (tmr_state == TMR_IDLE) |-> !tick_irq);

    // R5: an active timer never runs below the floor
    a_r5_floor: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (tmr_state != TMR_IDLE) |-> (run_lim >= CW'(MIN_CMP)));

    // R3: transferred value held until acknowledged
    a_r3_hold_until_ack: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (busy && !ack_match) |=> ($stable(xfer_val) && $stable(xfer_en)));

    // R8: a crossing pulse sets the flag
    a_r8_flag_set: assert property (@(posedge bus_clk) disable iff (bus_rst)
        evt_seen |=> flag);

    // R9: a clear strobe without a simultaneous pulse clears the flag
    a_r9_flag_clear: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (flag_clr && !evt_seen) |=> !flag);
endmodule

bind periodic_wake_timer pwt_checks #(.CW(CW), .MIN_CMP(MIN_CMP)) u_pwt_checks (
    .bus_clk   (bus_clk),
    .bus_rst   (bus_rst),
    .tmr_clk   (tmr_clk),
    .tmr_rst   (tmr_rst),
    .tick_irq  (tick_irq),
    .flag      (flag),
    .flag_clr  (flag_clr),
    .evt_seen  (evt_seen),
    .busy      (busy),
    .ack_match (ack_match),
    .xfer_en   (xfer_en),
    .xfer_val  (xfer_val),
    .tmr_state (tmr_state),
    .run_lim   (run_lim)
);

// File: tb/periodic_wake_timer_bench.sv
`timescale 1ns/100ps
module periodic_wake_timer_bench;
    localparam int CW = 12;

    logic          bus_clk  = 1'b0;
    logic          tmr_clk  = 1'b0;
    logic          bus_rst  = 1'b1;
    logic          tmr_rst  = 1'b1;
    logic          cfg_we   = 1'b0;
    logic          cfg_en   = 1'b0;
    logic [CW-1:0] cfg_val  = '0;
    logic          flag_clr = 1'b0;
    logic          flag;
    logic          tick_irq;

    int checks = 0;
    int fails  = 0;
    int tcount = 0;

    always #2.5  bus_clk = ~bus_clk;
    always #18.3 tmr_clk = ~tmr_clk;
    always @(posedge tmr_clk) tcount <= tcount + 1;

    periodic_wake_timer #(.CW(CW), .MIN_CMP(4)) u_periodic_wake_timer (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .cfg_we   (cfg_we),
        .cfg_en   (cfg_en),
        .cfg_val  (cfg_val),
        .flag_clr (flag_clr),
        .flag     (flag),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .tick_irq (tick_irq)
    );

    function automatic int exp_period(input logic en, input int val);
        if (!en || val == 0) return 0;
        if (val < 4) return 5;
        return val + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic write_cfg(input logic en, input int val, output int widx);
        @(negedge bus_clk);
        cfg_we  = 1'b1;
        cfg_en  = en;
        cfg_val = CW'(val);
        @(posedge bus_clk);
        #0.1;
        widx = tcount;
        @(negedge bus_clk);
        cfg_we = 1'b0;
    endtask

    task automatic next_irq(output int idx);
        int n = 0;
        idx = -1;
        while (n < 3000) begin
            @(negedge tmr_clk);
            n++;
            if (tick_irq) begin
                idx = tcount;
                break;
            end
        end
    endtask

    task automatic first_after(input int thr, output int idx);
        next_irq(idx);
        while (idx >= 0 && idx < thr) next_irq(idx);
    endtask

    task automatic quiet_count(output int seen);
        seen = 0;
        repeat (8) @(negedge tmr_clk);
        repeat (100) begin
            @(negedge tmr_clk);
            if (tick_irq) seen++;
        end
    endtask

    task automatic bus_wait(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    // Write, then check first-pulse position and two following periods
    task automatic run_case(input string req, input logic en, input int val);
        int w, a, b, c, p, seen;
        p = exp_period(en, val);
        write_cfg(en, val, w);
        if (p == 0) begin
            quiet_count(seen);
            chk({req, " parked"}, seen, 0);
        end else begin
            first_after(w + 5, a);
            chk_range({req, " first pulse (R6)"}, a - w, p + 4, p + 6);
            next_irq(b);
            next_irq(c);
            chk({req, " period (R4)"}, b - a, p);
            chk({req, " period (R4)"}, c - b, p);
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w, a, b, seen, dummy;
        dummy = $urandom(32'h0000_5EED);

        repeat (60) @(negedge bus_clk);
        bus_rst = 1'b0;
        @(negedge tmr_clk);
        tmr_rst = 1'b0;

        // R1: reset state
        chk("R1 flag after reset", flag, 0);
        chk("R1 tick after reset", tick_irq, 0);
        quiet_count(seen);
        chk("R1 no pulse unconfigured", seen, 0);

        // R4/R6: nominal value
        run_case("R4 val10", 1'b1, 10);

        // R5: clamp boundary
        run_case("R5 val2", 1'b1, 2);
        run_case("R5 val1", 1'b1, 1);
        run_case("R5 val4", 1'b1, 4);
        run_case("R5 val5", 1'b1, 5);

        // R7: restart mid-period
        write_cfg(1'b1, 30, w);
        next_irq(a);
        repeat (7) @(negedge tmr_clk);
        write_cfg(1'b1, 12, w);
        first_after(w + 5, a);
        chk_range("R7 restart first pulse", a - w, 17, 19);
        next_irq(b);
        chk("R7 restart period", b - a, 13);

        // R2: zero value and disabled write stop the timer
        run_case("R2 zero", 1'b1, 0);
        run_case("R2 disabled", 1'b0, 20);

        // R3: second write during transfer wins
        write_cfg(1'b1, 50, w);
        bus_wait(2);
        write_cfg(1'b1, 7, w);
        first_after(w + 5, a);
        next_irq(b);
        chk("R3 last write wins", b - a, 8);

        // R8/R9: sticky flag and clear
        write_cfg(1'b1, 0, w);
        quiet_count(seen);
        chk("R8 flag sticky while parked", flag, 1);
        bus_wait(40);
        chk("R8 flag still sticky", flag, 1);
        @(negedge bus_clk);
        flag_clr = 1'b1;
        @(negedge bus_clk);
        flag_clr = 1'b0;
        chk("R9 flag cleared", flag, 0);
        bus_wait(20);
        chk("R9 flag stays clear", flag, 0);
        write_cfg(1'b1, 9, w);
        next_irq(a);
        bus_wait(6);
        chk("R8 flag set by pulse", flag, 1);

        // Random configurations
        for (int i = 0; i < 6; i++) begin
            logic en;
            int   val;
            en  = ($urandom % 4) != 0;
            val = $urandom % 61;
            if (i == 0) val = 3;
            run_case("R4 random", en, val);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule